// File: doc/BRIEF.md
# Integer Register File and Execution Unit

This block is the integer datapath of a 64-bit core: a bank of sixteen general registers joined to a single-cycle arithmetic and logic unit. Every operation has two operands. The first is the destination register itself. The second comes either from a second register or from a zero-extended immediate. The result is written back into the destination register at the next rising clock edge.

Register 0 is a constant zero. An attempt to write to it is dropped, and the block raises a flag for that cycle. The arithmetic operations also produce a carry/borrow bit and a qualifier for it, which together feed the processor state register held outside this block. The destination and source registers can always be seen on two combinational read ports, so the surrounding pipeline sees each operand that the unit consumes.

Opcodes: move 0, and 1, or 2, xor 3, add 4, subtract 5, increment 6, decrement 7. Codes 8 to 15 are reserved.

Top module: `rfalu_core`

## Requirements
- R1: A synchronous reset, sampled at the rising edge, clears every register to zero. Both read ports return zero at the first cycle after reset.
- R2: Register 0 always reads as zero. A valid legal operation that names destination 0 writes nothing, and `illegal_dst` is high in that same cycle. `illegal_dst` is low in every other case.
- R3: Move (code 0) gives the second operand unchanged. And (code 1), or (code 2) and xor (code 3) give the bitwise combination of the destination and the second operand.
- R4: Add (code 4) gives the destination plus the second operand modulo 2^64, and `carry` equals bit 64 of the unsigned sum. Subtract (code 5) gives the destination minus the second operand modulo 2^64, and `carry` is high when the unsigned destination is less than the unsigned second operand.
- R5: Increment (code 6) gives the destination plus 1, with `carry` high when the destination was all ones. Decrement (code 7) gives the destination minus 1, with `carry` high when the destination was zero.
- R6: With `imm_sel` = 1 the second operand is `imm` zero-extended to 64 bits. With `imm_sel` = 0 it is the register selected by `src_idx`.
- R7: `carry_valid` is high only for a valid add, subtract, increment or decrement. Whenever `carry_valid` is low, `carry` is low.
- R8: A write takes effect at the rising edge after the operation is presented. In the cycle of the write, the read ports still return the old value.
- R9: With `op_valid` low, or with a reserved opcode (8 to 15), no register changes, `result` is zero, and `carry_valid` and `illegal_dst` are low.
- R10: `result`, `carry`, `carry_valid`, `illegal_dst` and both read ports are combinational functions of the current inputs and the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| dst_idx | input | 4 | Destination register and first operand |
| src_idx | input | 4 | Register for the second operand |
| imm_sel | input | 1 | 1: second operand is the immediate |
| imm | input | 16 | Immediate, zero-extended |
| rd_dst_data | output | 64 | Current contents of the destination register |
| rd_src_data | output | 64 | Current contents of the source register |
| result | output | 64 | Value being written back |
| carry | output | 1 | Carry or borrow to the state register |
| carry_valid | output | 1 | Qualifies `carry` |
| illegal_dst | output | 1 | Write to register 0 suppressed |

## Verification
The result, the flags and both read ports are due in the same cycle as the operation, with no register in their path. The register update is due one rising edge later. The bench drives each operation just after a falling edge and samples the combinational outputs 1 ns later, still before the next rising edge. It applies the expected write to its own register model only after those checks. The read ports of the next operation therefore confirm the commit a cycle later, and the read ports of the current operation confirm that the old value is returned during a write.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_AND = 4'd1,
        OP_OR  = 4'd2,
        OP_XOR = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_INC = 4'd6,
        OP_DEC = 4'd7
    } alu_op_e;

    localparam int OP_W = 4;

    function automatic logic op_is_legal(input logic [OP_W-1:0] code);
        return code < 4'd8;
    endfunction

endpackage

// File: rtl/rfalu_regfile.sv
module rfalu_regfile #(
    parameter int XLEN  = 64,
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);

    logic [XLEN-1:0] rf_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : gen_reg
        if (g == 0) begin : gen_zero
            assign rf_q[g] = '0;
        end else begin : gen_flop
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && wr_idx == IDX_W'(g)) begin
                    q <= wr_data;
                end
            end
            assign rf_q[g] = q;
        end
    end

    assign rd_a_data = rf_q[rd_a_idx];
    assign rd_b_data = rf_q[rd_b_idx];

endmodule

// File: rtl/rfalu_opsel.sv
module rfalu_opsel #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input  logic             imm_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  reg_val,
    output logic [XLEN-1:0]  operand
);

    localparam int PAD_W = XLEN - IMM_W;

    always_comb begin
        if (imm_sel) begin
            operand = {{PAD_W{1'b0}}, imm};
        end else begin
            operand = reg_val;
        end
    end

endmodule

// File: rtl/rfalu_alu.sv
module rfalu_alu
    import rfalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [OP_W-1:0] op_code,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            cy,
    output logic            cy_vld
);

    localparam int WIDE = XLEN + 1;

    logic [WIDE-1:0] sum_w;
    logic [WIDE-1:0] dif_w;
    logic [WIDE-1:0] inc_w;
    logic [WIDE-1:0] dec_w;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, a} - {1'b0, b};
    assign inc_w = {1'b0, a} + WIDE'(1);
    assign dec_w = {1'b0, a} - WIDE'(1);

    always_comb begin
        res    = '0;
        cy     = 1'b0;
        cy_vld = 1'b0;
        unique case (op_code)
            OP_MOV: res = b;
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_ADD: begin
                res    = sum_w[XLEN-1:0];
                cy     = sum_w[XLEN];
                cy_vld = 1'b1;
            end
            OP_SUB: begin
                res    = dif_w[XLEN-1:0];
                cy     = dif_w[XLEN];
                cy_vld = 1'b1;
            end
            OP_INC: begin
                res    = inc_w[XLEN-1:0];
                cy     = inc_w[XLEN];
                cy_vld = 1'b1;
            end
            OP_DEC: begin
                res    = dec_w[XLEN-1:0];
                cy     = dec_w[XLEN];
                cy_vld = 1'b1;
            end
            default: begin
                res    = '0;
                cy     = 1'b0;
                cy_vld = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rfalu_core.sv
module rfalu_core
    import rfalu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREG  = 16,
    parameter int IMM_W = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    input  logic             imm_sel,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  rd_dst_data,
    output logic [XLEN-1:0]  rd_src_data,
    output logic [XLEN-1:0]  result,
    output logic             carry,
    output logic             carry_valid,
    output logic             illegal_dst
);

    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_cy;
    logic            alu_cy_vld;
    logic            legal;
    logic            dst_zero;
    logic            wr_en;

    rfalu_regfile #(
        .XLEN  (XLEN),
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (dst_idx),
        .rd_a_data (rd_dst_data),
        .rd_b_idx  (src_idx),
        .rd_b_data (rd_src_data),
        .we        (wr_en),
        .wr_idx    (dst_idx),
        .wr_data   (result)
    );

    rfalu_opsel #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_opsel (
        .imm_sel (imm_sel),
        .imm     (imm),
        .reg_val (rd_src_data),
        .operand (opnd_b)
    );

    rfalu_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op_code (op_code),
        .a       (rd_dst_data),
        .b       (opnd_b),
        .res     (alu_res),
        .cy      (alu_cy),
        .cy_vld  (alu_cy_vld)
    );

    always_comb begin
        legal       = op_valid && op_is_legal(op_code);
        dst_zero    = (dst_idx == '0);
        wr_en       = legal && !dst_zero;
        illegal_dst = legal && dst_zero;
        result      = legal ? alu_res : '0;
        carry_valid = op_valid && alu_cy_vld;
        carry       = carry_valid && alu_cy;
    end

endmodule

// File: rtl/rfalu_chk.sv
module rfalu_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [IDX_W-1:0] dst_idx,
    input logic [XLEN-1:0]  rd_dst_data,
    input logic [XLEN-1:0]  rd_src_data,
    input logic [XLEN-1:0]  result,
    input logic             carry,
    input logic             carry_valid,
    input logic             illegal_dst,
    input logic             wr_en
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_dst_data == '0 && rd_src_data == '0));

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_idx == '0) |-> (rd_dst_data == '0));

    // R2
    zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_dst |-> !wr_en);

    // R7
    carry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_valid |-> !carry);

    // R8
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dst_idx != $past(dst_idx) || rd_dst_data == $past(result)));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!wr_en && !carry_valid && !illegal_dst && result == '0));

endmodule

bind rfalu_core rfalu_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_rfalu_core.sv
module test_rfalu_core;

    localparam int XLEN  = 64;
    localparam int NREG  = 16;
    localparam int IMM_W = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             op_valid = 1'b0;
    logic [3:0]       op_code = '0;
    logic [IDX_W-1:0] dst_idx = '0;
    logic [IDX_W-1:0] src_idx = '0;
    logic             imm_sel = 1'b0;
    logic [IMM_W-1:0] imm = '0;
    logic [XLEN-1:0]  rd_dst_data;
    logic [XLEN-1:0]  rd_src_data;
    logic [XLEN-1:0]  result;
    logic             carry;
    logic             carry_valid;
    logic             illegal_dst;

    int n_chk = 0;
    int n_bad = 0;
    logic [XLEN-1:0] m [NREG];

    always #2 clk = ~clk;

    rfalu_core i_rfalu_core (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .dst_idx     (dst_idx),
        .src_idx     (src_idx),
        .imm_sel     (imm_sel),
        .imm         (imm),
        .rd_dst_data (rd_dst_data),
        .rd_src_data (rd_src_data),
        .result      (result),
        .carry       (carry),
        .carry_valid (carry_valid),
        .illegal_dst (illegal_dst)
    );

    task automatic cmp(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input bit v, input int d);
        if (!v || op > 4'd7) return "R9";
        if (d == 0)           return "R2";
        if (op < 4'd4)        return "R3";
        if (op < 4'd6)        return "R4";
        return "R5";
    endfunction

    task automatic apply(input bit v, input logic [3:0] op, input int d, input int s,
                         input bit is, input logic [IMM_W-1:0] im, input string req);
        logic [XLEN-1:0] a, b, r;
        logic c, cv, il, wr, lg;
        @(negedge clk);
        op_valid = v; op_code = op; dst_idx = d[IDX_W-1:0];
        src_idx = s[IDX_W-1:0]; imm_sel = is; imm = im;
        #1;
        a  = m[d];
        b  = is ? {{(XLEN-IMM_W){1'b0}}, im} : m[s];
        r  = '0; c = 1'b0; cv = 1'b0;
        lg = v && (op < 4'd8);
        if (lg) begin
            case (op)
                4'd0: r = b;
                4'd1: r = a & b;
                4'd2: r = a | b;
                4'd3: r = a ^ b;
                4'd4: begin {c, r} = {1'b0, a} + {1'b0, b}; cv = 1'b1; end
                4'd5: begin r = a - b; c = (a < b); cv = 1'b1; end
                4'd6: begin r = a + 1; c = (a == '1); cv = 1'b1; end
                default: begin r = a - 1; c = (a == '0); cv = 1'b1; end
            endcase
        end
        il = lg && (d == 0);
        wr = lg && (d != 0);
        cmp(req, "result", result, r);
        cmp(req, "carry", {63'b0, carry}, {63'b0, c});
        cmp("R7", "carry_valid", {63'b0, carry_valid}, {63'b0, cv});
        cmp("R2", "illegal_dst", {63'b0, illegal_dst}, {63'b0, il});
        cmp("R8", "rd_dst_data (old value)", rd_dst_data, m[d]);
        cmp("R8", "rd_src_data", rd_src_data, m[s]);
        if (wr) m[d] = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) m[i] = '0;
        // R1: every register reads zero after reset
        for (int i = 0; i < NREG; i++) apply(1'b0, 4'd0, i, (i + 1) % NREG, 1'b0, '0, "R1");
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) m[i] = '0;
        do_reset();

        // R6: immediate zero-extended
        apply(1'b1, 4'd0, 1, 0, 1'b1, 16'hFFFF, "R6");
        // R3: move from register
        apply(1'b1, 4'd0, 2, 1, 1'b0, '0, "R3");
        // R5: decrement of zero wraps with borrow
        apply(1'b1, 4'd7, 3, 0, 1'b0, '0, "R5");
        // R5: increment of all ones wraps with carry
        apply(1'b1, 4'd6, 3, 0, 1'b0, '0, "R5");
        apply(1'b1, 4'd7, 4, 0, 1'b0, '0, "R5");
        // R4: add overflow sets carry
        apply(1'b1, 4'd4, 4, 1, 1'b0, '0, "R4");
        // R4: subtract with borrow
        apply(1'b1, 4'd0, 5, 0, 1'b1, 16'd1, "R6");
        apply(1'b1, 4'd5, 5, 0, 1'b1, 16'd2, "R4");
        apply(1'b1, 4'd5, 5, 5, 1'b0, '0, "R4");
        // R3: logic ops
        apply(1'b1, 4'd1, 2, 0, 1'b1, 16'h0F0F, "R3");
        apply(1'b1, 4'd2, 2, 4, 1'b0, '0, "R3");
        apply(1'b1, 4'd3, 2, 1, 1'b0, '0, "R3");
        // R2: write to register 0 dropped
        apply(1'b1, 4'd4, 0, 1, 1'b0, '0, "R2");
        apply(1'b1, 4'd0, 0, 2, 1'b0, '0, "R2");
        apply(1'b0, 4'd0, 0, 0, 1'b0, '0, "R2");
        // R9: reserved code and idle cycle change nothing
        apply(1'b1, 4'd9, 2, 1, 1'b0, '0, "R9");
        apply(1'b0, 4'd4, 2, 1, 1'b0, '0, "R9");
        apply(1'b0, 4'd0, 2, 1, 1'b0, '0, "R9");
        // R8: back-to-back writes to one register
        apply(1'b1, 4'd6, 6, 0, 1'b0, '0, "R8");
        apply(1'b1, 4'd6, 6, 6, 1'b0, '0, "R8");
        apply(1'b1, 4'd4, 6, 6, 1'b0, '0, "R8");

        // R10: random operations, outputs checked in the operation's own cycle
        for (int k = 0; k < 1500; k++) begin
            logic [3:0] op;
            bit v;
            int d, s;
            op = 4'($urandom % 9);
            v  = ($urandom % 8) != 0;
            d  = int'($urandom % NREG);
            s  = int'($urandom % NREG);
            apply(v, op, d, s, bit'($urandom % 2), IMM_W'($urandom), tag_of(op, v, d));
        end

        do_reset();
        apply(1'b1, 4'd7, 7, 0, 1'b0, '0, "R5");
        apply(1'b1, 4'd4, 7, 0, 1'b1, 16'd1, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule